// File: doc/BRIEF.md
# Step Attenuator Control Decoder

This block is the digital control front end of a seven-bit step attenuator with 0.25 dB resolution. It turns the control pins into one registered attenuation code. Three sources can load that code. The first is an eight-bit serial word, shifted in least significant bit first and committed on a rising latch enable. The second is a transparent parallel path that follows the parallel pins while latch enable is high. The third is an edge-captured parallel path that takes the pins on a latch-enable rising edge and holds them while latch enable is low.

The mode pin chooses between the serial and parallel paths. A floating pin reads as low, which selects parallel. The mode pin, latch enable, serial clock and serial data are asynchronous to the system clock. They pass through a two-flop synchronizer bank, and edges are found by comparing each synchronized value with its previous value. Reset puts the code at full scale (31.75 dB). A one-cycle strobe marks every change in the code's value.

Top module: `atten_ctrl`

## Requirements
- R1: During and immediately after synchronous reset, `atten_code` is 7'b1111111, whatever the levels on `mode_sel`, `par_code` and the other control inputs.
- R2: With `mode_sel` high, each rising edge of `ser_clk` seen while latch enable is low shifts `ser_data` into an 8-bit register, least significant bit first. A rising edge of `latch_en` then copies bits 6..0 of that register into `atten_code`. Bit 7, the last bit sent, is ignored. Code bit k weighs 0.25·2^k dB.
- R3: A `ser_clk` rising edge that arrives while latch enable is high does not shift, so a later latch pulse with no clocks in between reloads the previous word.
- R4: When more than 8 bits are shifted before a latch edge, only the last 8 received determine the code.
- R5: With `mode_sel` low and `latch_en` high, `atten_code` equals the `par_code` value of the previous clock cycle.
- R6: With `mode_sel` low and `latch_en` low, changes on `par_code` leave `atten_code` unchanged.
- R7: With `mode_sel` low, a rising edge of `latch_en` captures `par_code` into `atten_code`.
- R8: `code_upd` is high for exactly the cycles in which `atten_code` has just taken a new value. Loading a value equal to the current code gives no strobe.
- R9: With `mode_sel` high, `par_code` has no effect, even while `latch_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 1 | 1 selects serial loading, 0 selects parallel loading (asynchronous) |
| latch_en | input | 1 | Latch enable: commit edge, or transparent level in parallel mode (asynchronous) |
| ser_clk | input | 1 | Serial shift clock, sampled for rising edges (asynchronous) |
| ser_data | input | 1 | Serial data bit (asynchronous) |
| par_code | input | 7 | Parallel attenuation code |
| atten_code | output | 7 | Registered attenuation code, LSB = 0.25 dB |
| code_upd | output | 1 | One-cycle strobe when atten_code changes |

## Verification
A change on `latch_en`, `ser_clk`, `ser_data` or `mode_sel` needs two synchronizer clocks and one edge-compare clock. A latched or serial result is therefore due on the third clock edge after the input changes, and `code_upd` rises on that same edge. In transparent mode, a change on `par_code` appears in `atten_code` on the first clock edge. The bench drives inputs on falling edges and holds every serial and latch level for at least four clocks. Its monitor samples on falling edges and matches each strobe against a queue of expected codes. After every stimulus that must be ignored, the bench checks that the code is unchanged and the queue is empty.

// File: rtl/atten_pkg.sv
package atten_pkg;
    localparam int CODE_W = 7;
    localparam int WORD_W = 8;
    localparam int SYNC_STAGES = 2;

    typedef logic [CODE_W-1:0] code_t;
    typedef logic [WORD_W-1:0] word_t;

    localparam code_t FULL_SCALE = '1;

    typedef enum logic [1:0] {
        SRC_HOLD     = 2'd0,
        SRC_SERIAL   = 2'd1,
        SRC_PARALLEL = 2'd2
    } src_e;

    typedef struct packed {
        logic mode;
        logic le;
        logic sck;
        logic sdi;
    } ctl_t;

    localparam int CTL_W = $bits(ctl_t);

    function automatic word_t shift_lsb_first(word_t w, logic b);
        return {b, w[WORD_W-1:1]};
    endfunction
endpackage

// File: rtl/atten_sync.sv
module atten_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q,
    output logic [W-1:0] q_prev
);
    logic [W-1:0] stg [STAGES+1];

    always_ff @(posedge clk) begin
        if (rst) stg[0] <= '0;
        else     stg[0] <= d;
    end

    for (genvar i = 1; i <= STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stg[i] <= '0;
            else     stg[i] <= stg[i-1];
        end
    end

    assign q      = stg[STAGES-1];
    assign q_prev = stg[STAGES];
endmodule

// File: rtl/atten_shifter.sv
module atten_shifter
    import atten_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  shift_en,
    input  logic  bit_in,
    output word_t word
);
    always_ff @(posedge clk) begin
        if (rst)           word <= '0;
        else if (shift_en) word <= shift_lsb_first(word, bit_in);
    end
endmodule

// File: rtl/atten_loader.sv
module atten_loader
    import atten_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  ld_serial,
    input  logic  ld_par,
    input  code_t ser_code,
    input  code_t par_code,
    output code_t code,
    output logic  upd
);
    src_e  src;
    code_t nxt;

    always_comb begin
        if (ld_serial)   src = SRC_SERIAL;
        else if (ld_par) src = SRC_PARALLEL;
        else             src = SRC_HOLD;
        case (src)
            SRC_SERIAL:   nxt = ser_code;
            SRC_PARALLEL: nxt = par_code;
            default:      nxt = code;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            code <= FULL_SCALE;
            upd  <= 1'b0;
        end else begin
            code <= nxt;
            upd  <= (nxt != code);
        end
    end

    AST_HOLD_NO_LOAD: assert property (@(posedge clk) disable iff (rst)
        !(ld_serial || ld_par) |=> $stable(code)); // R6
    AST_UPD_MEANS_CHANGE: assert property (@(posedge clk) disable iff (rst)
        upd |-> (code != $past(code))); // R8
    AST_NO_UPD_STABLE: assert property (@(posedge clk) disable iff (rst)
        !upd |-> $stable(code)); // R8
endmodule

// File: rtl/atten_ctrl.sv
module atten_ctrl
    import atten_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_sel,
    input  logic              latch_en,
    input  logic              ser_clk,
    input  logic              ser_data,
    input  logic [CODE_W-1:0] par_code,
    output logic [CODE_W-1:0] atten_code,
    output logic              code_upd
);
    ctl_t  raw, cur, prv;
    word_t shreg;
    logic  le_rise, sck_rise, shift_en, ld_serial, ld_par;
    code_t code_q;

    assign raw = '{mode: mode_sel, le: latch_en, sck: ser_clk, sdi: ser_data};

    atten_sync #(.W(CTL_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .d(raw), .q(cur), .q_prev(prv)
    );

    assign le_rise   = cur.le & ~prv.le;
    assign sck_rise  = cur.sck & ~prv.sck;
    assign shift_en  = sck_rise & ~cur.le;
    assign ld_serial = cur.mode & le_rise;
    assign ld_par    = ~cur.mode & cur.le;

    atten_shifter u_shift (
        .clk(clk), .rst(rst), .shift_en(shift_en), .bit_in(cur.sdi), .word(shreg)
    );

    atten_loader u_load (
        .clk(clk), .rst(rst), .ld_serial(ld_serial), .ld_par(ld_par),
        .ser_code(shreg[CODE_W-1:0]), .par_code(par_code),
        .code(code_q), .upd(code_upd)
    );

    assign atten_code = code_q;

    AST_RESET_FULL: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (atten_code == FULL_SCALE)); // R1
    AST_SHIFT_FROZEN_LE: assert property (@(posedge clk) disable iff (rst)
        cur.le |=> $stable(shreg)); // R3
    AST_DIRECT_FOLLOW: assert property (@(posedge clk) disable iff (rst)
        (!cur.mode && cur.le) |=> (atten_code == $past(par_code))); // R5
    AST_SERIAL_IGNORES_PAR: assert property (@(posedge clk) disable iff (rst)
        (cur.mode && !le_rise) |=> $stable(atten_code)); // R9
endmodule

// File: tb/sim_atten_ctrl.sv
module sim_atten_ctrl;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       mode_sel = 1'b1, latch_en = 1'b0, ser_clk = 1'b0, ser_data = 1'b0;
    logic [6:0] par_code = 7'h15;
    logic [6:0] atten_code;
    logic       code_upd;

    int   n_chk = 0, n_fail = 0;
    bit   done = 0;
    logic [6:0] exp_q[$];
    logic [6:0] model = 7'h7F;

    always #10 clk = ~clk;

    atten_ctrl u0 (
        .clk(clk), .rst(rst), .mode_sel(mode_sel), .latch_en(latch_en),
        .ser_clk(ser_clk), .ser_data(ser_data), .par_code(par_code),
        .atten_code(atten_code), .code_upd(code_upd)
    );

    task automatic chk(input string req, input logic [6:0] act, input logic [6:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic expect_load(input logic [6:0] v);
        if (v != model) exp_q.push_back(v);
        model = v;
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bits(input logic [15:0] bits, input int n);
        for (int i = 0; i < n; i++) begin
            ser_data = bits[i];
            wait_clk(3);
            ser_clk = 1'b1;
            wait_clk(4);
            ser_clk = 1'b0;
            wait_clk(3);
        end
    endtask

    task automatic pulse_le();
        latch_en = 1'b1;
        wait_clk(6);
        latch_en = 1'b0;
        wait_clk(5);
    endtask

    // monitor: every strobe must match the next expected code
    always @(negedge clk) begin
        if (!rst && code_upd) begin
            if (exp_q.size() == 0) chk("R8 unexpected strobe", atten_code, model);
            else chk("R8 strobe value", atten_code, exp_q.pop_front());
        end
    end

    task automatic chk_idle(input string req);
        chk(req, atten_code, model);
        chk({req, " pending"}, 7'(exp_q.size()), 7'd0);
    endtask

    initial begin
        wait_clk(4);
        chk("R1 code in reset", atten_code, 7'h7F);
        rst = 1'b0;
        wait_clk(1);
        chk("R1 code after reset", atten_code, 7'h7F);
        wait_clk(10);
        chk_idle("R1 hold after reset");

        // R2 serial word 0xAA: bit7 ignored -> 0x2A
        expect_load(7'h2A);
        send_bits(16'h00AA, 8);
        pulse_le();
        chk_idle("R2 serial 0xAA");
        expect_load(7'h01);
        send_bits(16'h0001, 8);
        pulse_le();
        chk_idle("R2 serial 0x01");
        // R8 same code with bit7 set: no strobe
        expect_load(7'h01);
        send_bits(16'h0081, 8);
        pulse_le();
        chk_idle("R8 equal reload");

        // R3 clocks while latch enable high are ignored
        latch_en = 1'b1;
        wait_clk(6);
        send_bits(16'h007F, 3);
        latch_en = 1'b0;
        wait_clk(5);
        pulse_le();
        chk_idle("R3 clocks during latch");

        // R4 eleven bits: last eight form 0x35
        expect_load(7'h35);
        send_bits({5'b0, 8'h35, 3'b111}, 11);
        pulse_le();
        chk_idle("R4 overlong word");

        // R9 serial mode ignores parallel pins with latch high
        latch_en = 1'b1;
        wait_clk(6);
        par_code = 7'h0F;
        wait_clk(6);
        chk_idle("R9 par in serial");
        latch_en = 1'b0;
        wait_clk(5);

        // R6 parallel mode, latch low: pins ignored
        mode_sel = 1'b0;
        wait_clk(6);
        par_code = 7'h40;
        wait_clk(8);
        chk_idle("R6 latch low hold");
        // R7 latch rising edge captures
        expect_load(7'h40);
        latch_en = 1'b1;
        wait_clk(6);
        chk_idle("R7 latched capture");

        // R5 transparent: follows pins on next clock
        par_code = 7'h12;
        expect_load(7'h12);
        wait_clk(1);
        chk("R5 direct 0x12", atten_code, 7'h12);
        par_code = 7'h00;
        expect_load(7'h00);
        wait_clk(1);
        chk("R5 direct 0x00", atten_code, 7'h00);
        par_code = 7'h7F;
        expect_load(7'h7F);
        wait_clk(1);
        chk("R5 direct 0x7F", atten_code, 7'h7F);
        wait_clk(4);
        chk_idle("R5 direct settle");
        latch_en = 1'b0;
        wait_clk(5);
        par_code = 7'h03;
        wait_clk(6);
        chk_idle("R6 after direct");

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule